// File: doc/BRIEF.md
# WFI Sleep Clock-Enable Controller

This block decides when the processor core's clock may stop. It runs entirely on the free-running clock. When the core reports that it has executed a wait-for-interrupt instruction and no machine-mode interrupt is pending, the block drops a registered clock-gate enable. The enable goes to an external clock-gate cell, which cuts the core's clock. The block raises the enable again on the clock edge that follows the cycle in which any of the three interrupt sources (software, timer, external) is pending.

Each interrupt input is also latched into a sticky per-source flag. Because of this, a request that lasts only one cycle still wakes the core and is still visible to the core once its clock runs. A flag holds until the core writes a one to the matching bit of the clear input. Right after a wake, the block spends one cycle in a wake state. In that cycle it ignores the wait request, because the core may still be driving a stale request from before the sleep.

Top module: `wfi_clk_gate_pm`

## Requirements
- R1: While reset is asserted and right after it is released, `core_clk_en` is 1 and `irq_seen` is all zeros.
- R2: When the block is running and `wfi_req` is 1, and no bit of `irq_raw` or `irq_seen` is set, `core_clk_en` is 0 after the next clock edge.
- R3: If any bit of `irq_raw` or `irq_seen` is set in the cycle where `wfi_req` is 1, `core_clk_en` stays 1.
- R4: While `core_clk_en` is 0, a 1 on any bit of `irq_raw` in a cycle makes `core_clk_en` 1 after that cycle's clock edge. This is a one-cycle wake.
- R5: A 1 on bit i of `irq_raw` for one cycle sets bit i of `irq_seen` after that clock edge. The bit then stays 1 while the matching clear bit is 0.
- R6: A 1 on bit i of `irq_clr` while bit i of `irq_raw` is 0 clears bit i of `irq_seen` after the next edge. The other bits are unchanged.
- R7: When bit i of `irq_raw` and bit i of `irq_clr` are both 1 in the same cycle, bit i of `irq_seen` is 1 after the edge. Setting wins over clearing.
- R8: In the first cycle after a wake, `wfi_req` is ignored and `core_clk_en` stays 1. A request in the following cycle, with nothing pending, is honoured.
- R9: The source bit positions are fixed: bit 0 is software, bit 1 is timer and bit 2 is external. Each source alone can wake the block and is captured in its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_free | input | 1 | Free-running clock, never gated |
| rst_n | input | 1 | Active-low synchronous reset |
| wfi_req | input | 1 | Core reports that it has executed a wait-for-interrupt instruction |
| irq_raw | input | 3 | Raw interrupt requests: [0] software, [1] timer, [2] external |
| irq_clr | input | 3 | Per-source acknowledge from the core; clears the captured flag |
| irq_seen | output | 3 | Captured interrupt flags, presented to the core |
| core_clk_en | output | 1 | Registered enable for the core clock-gate cell |

## Verification
Two collisions matter most. The first is a wait request that arrives in the same cycle as a raw interrupt, or while a captured flag is still set. The bench drives both together and expects the enable to stay high. The second is a raw interrupt on a source in the same cycle as the core's clear of that source. The bench applies both in one cycle and expects the flag to remain set. A third case is a stale wait request held through the wake cycle while the flags are being cleared: the enable must not fall until the following cycle. In every case a behavioural model in the bench predicts the enable and the flags, and the bench compares them on every cycle.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

   typedef enum logic [1:0] {
      PM_RUN   = 2'd0,
      PM_SLEEP = 2'd1,
      PM_WAKE  = 2'd2
   } pm_state_e;

   localparam int PM_SRC_SW    = 0;
   localparam int PM_SRC_TIMER = 1;
   localparam int PM_SRC_EXT   = 2;
   localparam int PM_NUM_SRC   = 3;

endpackage

// File: rtl/pmu_irq_latch.sv
module pmu_irq_latch #(
   parameter int IRQ_W    = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IRQ_W-1:0] irq_raw,
   input  logic [IRQ_W-1:0] irq_clr,
   output logic [IRQ_W-1:0] irq_hold,
   output logic             pend_any
);

   logic [IRQ_W-1:0] hold_q;
   logic [IRQ_W-1:0] hold_d;

   for (genvar gi = 0; gi < IRQ_W; gi++) begin : g_src
      if (SET_WINS) begin : g_set_first
         assign hold_d[gi] = irq_raw[gi] | (hold_q[gi] & ~irq_clr[gi]);
      end else begin : g_clr_first
         assign hold_d[gi] = (irq_raw[gi] | hold_q[gi]) & ~irq_clr[gi];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) hold_q <= '0;
      else        hold_q <= hold_d;
   end

   assign irq_hold = hold_q;
   assign pend_any = |(irq_raw | hold_q);

endmodule

// File: rtl/pmu_sleep_fsm.sv
module pmu_sleep_fsm
   import pmu_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wfi_req,
   input  logic      pend_any,
   output logic      clk_en,
   output pm_state_e state
);

   pm_state_e state_q;
   pm_state_e state_d;
   logic      en_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PM_RUN:   if (wfi_req && !pend_any) state_d = PM_SLEEP;
         PM_SLEEP: if (pend_any)             state_d = PM_WAKE;
         PM_WAKE:                            state_d = PM_RUN;
         default:                            state_d = PM_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PM_RUN;
         en_q    <= 1'b1;
      end else begin
         state_q <= state_d;
         en_q    <= (state_d != PM_SLEEP);
      end
   end

   assign clk_en = en_q;
   assign state  = state_q;

endmodule

// File: rtl/wfi_clk_gate_pm.sv
module wfi_clk_gate_pm
   import pmu_pkg::*;
#(
   parameter int IRQ_W    = PM_NUM_SRC,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk_free,
   input  logic             rst_n,
   input  logic             wfi_req,
   input  logic [IRQ_W-1:0] irq_raw,
   input  logic [IRQ_W-1:0] irq_clr,
   output logic [IRQ_W-1:0] irq_seen,
   output logic             core_clk_en
);

   if (IRQ_W != PM_NUM_SRC) begin : g_bad_width
      $error("wfi_clk_gate_pm: IRQ_W must equal the number of sources");
   end

   logic      pend_any;
   pm_state_e state_q;

   pmu_irq_latch #(
      .IRQ_W    (IRQ_W),
      .SET_WINS (SET_WINS)
   ) u_latch (
      .clk      (clk_free),
      .rst_n    (rst_n),
      .irq_raw  (irq_raw),
      .irq_clr  (irq_clr),
      .irq_hold (irq_seen),
      .pend_any (pend_any)
   );

   pmu_sleep_fsm u_fsm (
      .clk      (clk_free),
      .rst_n    (rst_n),
      .wfi_req  (wfi_req),
      .pend_any (pend_any),
      .clk_en   (core_clk_en),
      .state    (state_q)
   );

endmodule

// File: rtl/wfi_pm_checker.sv
module wfi_pm_checker #(
   parameter int IRQ_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wfi_req,
   input logic [IRQ_W-1:0] irq_raw,
   input logic [IRQ_W-1:0] irq_clr,
   input logic [IRQ_W-1:0] irq_seen,
   input logic             clk_en,
   input logic [1:0]       state
);

   // R2
   a_r2_sleep_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 2'd0 && wfi_req && irq_raw == '0 && irq_seen == '0) |=> !clk_en);

   // R3
   a_r3_no_sleep_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && (irq_raw != '0 || irq_seen != '0)) |=> clk_en);

   // R4
   a_r4_one_cycle_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_en && irq_raw != '0) |=> clk_en);

   // R5
   a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_raw != '0) |=> ((irq_seen & $past(irq_raw)) == $past(irq_raw)));

   // R6
   a_r6_hold_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_seen & ~irq_clr) != '0) |=>
         ((irq_seen & $past(irq_seen & ~irq_clr)) == $past(irq_seen & ~irq_clr)));

   // R6
   a_r6_clear_only_raised: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_clr & ~irq_raw) != '0) |=> ((irq_seen & $past(irq_clr & ~irq_raw)) == '0));

   // R8
   a_r8_wake_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |=> clk_en);

endmodule

bind wfi_clk_gate_pm wfi_pm_checker #(.IRQ_W(IRQ_W)) u_wfi_pm_checker (
   .clk      (clk_free),
   .rst_n    (rst_n),
   .wfi_req  (wfi_req),
   .irq_raw  (irq_raw),
   .irq_clr  (irq_clr),
   .irq_seen (irq_seen),
   .clk_en   (core_clk_en),
   .state    (state_q)
);

// File: tb/tb_wfi_clk_gate_pm.sv
`timescale 1ns/1ps
module tb_wfi_clk_gate_pm;

   logic       clk_free = 1'b0;
   logic       rst_n    = 1'b0;
   logic       wfi_req  = 1'b0;
   logic [2:0] irq_raw  = '0;
   logic [2:0] irq_clr  = '0;
   logic [2:0] irq_seen;
   logic       core_clk_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk_free = ~clk_free;   // 50 MHz

   wfi_clk_gate_pm dut (
      .clk_free    (clk_free),
      .rst_n       (rst_n),
      .wfi_req     (wfi_req),
      .irq_raw     (irq_raw),
      .irq_clr     (irq_clr),
      .irq_seen    (irq_seen),
      .core_clk_en (core_clk_en)
   );

   // behavioural reference: 0 running, 1 asleep, 2 just woke
   int         m_mode = 0;
   logic [2:0] m_flags = '0;
   logic       m_en = 1'b1;

   always @(posedge clk_free) begin
      int nxt;
      if (!rst_n) begin
         m_mode  <= 0;
         m_flags <= '0;
         m_en    <= 1'b1;
      end else begin
         nxt = m_mode;
         if (m_mode == 0 && wfi_req && (irq_raw | m_flags) == 3'b000) nxt = 1;
         else if (m_mode == 1 && (irq_raw | m_flags) != 3'b000)       nxt = 2;
         else if (m_mode == 2)                                          nxt = 0;
         m_mode  <= nxt;
         m_en    <= (nxt != 1);
         m_flags <= irq_raw | (m_flags & ~irq_clr);
      end
   end

   task automatic chk(string req, logic [2:0] got, logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk_free) begin
      if (rst_n && !done) begin
         chk("R2 model clk_en", {2'b00, core_clk_en}, {2'b00, m_en});
         chk("R5 model flags", irq_seen, m_flags);
      end
   end

   task automatic step(logic w, logic [2:0] r, logic [2:0] c);
      wfi_req = w; irq_raw = r; irq_clr = c;
      @(negedge clk_free);
      wfi_req = 1'b0; irq_raw = '0; irq_clr = '0;
   endtask

   initial begin
      repeat (5000) @(posedge clk_free);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_free);
      chk("R1 en in reset", {2'b00, core_clk_en}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk_free);
      chk("R1 en after reset", {2'b00, core_clk_en}, 3'b001);
      chk("R1 flags after reset", irq_seen, 3'b000);

      // R2: sleep entry
      step(1'b1, 3'b000, 3'b000);
      chk("R2 gated", {2'b00, core_clk_en}, 3'b000);
      step(1'b0, 3'b000, 3'b000);
      step(1'b0, 3'b000, 3'b000);
      chk("R2 stays gated", {2'b00, core_clk_en}, 3'b000);

      // R4 / R5 / R9: timer pulse (bit 1) wakes in one cycle
      step(1'b0, 3'b010, 3'b000);
      chk("R4 timer wake", {2'b00, core_clk_en}, 3'b001);
      chk("R9 timer bit", irq_seen, 3'b010);

      // R8: stale request during wake cycle, flags cleared together
      step(1'b1, 3'b000, 3'b111);
      chk("R8 wake ignores wfi", {2'b00, core_clk_en}, 3'b001);
      chk("R6 clear all", irq_seen, 3'b000);
      step(1'b1, 3'b000, 3'b000);
      chk("R8 next request honoured", {2'b00, core_clk_en}, 3'b000);

      // R9: software bit 0
      step(1'b0, 3'b001, 3'b000);
      chk("R9 software wake", {2'b00, core_clk_en}, 3'b001);
      chk("R9 software bit", irq_seen, 3'b001);
      step(1'b0, 3'b000, 3'b001);
      step(1'b1, 3'b000, 3'b000);
      chk("R2 gated again", {2'b00, core_clk_en}, 3'b000);

      // R9: external bit 2, pulse held then model follows
      step(1'b0, 3'b100, 3'b000);
      chk("R9 external wake", {2'b00, core_clk_en}, 3'b001);
      chk("R9 external bit", irq_seen, 3'b100);
      step(1'b0, 3'b000, 3'b000);
      step(1'b0, 3'b000, 3'b000);
      chk("R5 flag held", irq_seen, 3'b100);

      // R3: request while a captured flag is set
      step(1'b1, 3'b000, 3'b000);
      chk("R3 captured blocks sleep", {2'b00, core_clk_en}, 3'b001);
      step(1'b0, 3'b000, 3'b100);
      chk("R6 ext cleared", irq_seen, 3'b000);

      // R3: request in the same cycle as a raw pulse
      step(1'b1, 3'b001, 3'b000);
      chk("R3 raw blocks sleep", {2'b00, core_clk_en}, 3'b001);
      chk("R5 raw captured", irq_seen, 3'b001);

      // R6: per-source clear leaves others
      step(1'b0, 3'b100, 3'b000);
      chk("R5 second flag", irq_seen, 3'b101);
      step(1'b0, 3'b000, 3'b001);
      chk("R6 selective clear", irq_seen, 3'b100);

      // R7: set and clear in the same cycle
      step(1'b0, 3'b100, 3'b100);
      chk("R7 set wins", irq_seen, 3'b100);
      step(1'b0, 3'b000, 3'b100);
      chk("R6 final clear", irq_seen, 3'b000);

      // R4: multiple sources at once while asleep
      step(1'b1, 3'b000, 3'b000);
      chk("R2 gated final", {2'b00, core_clk_en}, 3'b000);
      step(1'b0, 3'b011, 3'b000);
      chk("R4 multi wake", {2'b00, core_clk_en}, 3'b001);
      chk("R5 multi capture", irq_seen, 3'b011);
      step(1'b0, 3'b000, 3'b000);
      step(1'b0, 3'b000, 3'b000);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule